// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block works out which column a synchronous DRAM burst touches on each beat. A controller pulses a start strobe and presents the first column, the burst-length code, the ordering mode and whether the access is a write. From the next cycle on, the block puts out one column per clock with a valid flag. The final beat of a fixed-length burst is marked with a last flag.

Two orderings are available. Sequential ordering counts upward and wraps inside the aligned block whose size is the burst length. Interleaved ordering takes the start column's offset in that block and XORs it with the beat number. A full-row burst covers all 512 columns of a row, starting at the given column and wrapping at the row end. It runs until a terminate strobe stops it or a new start replaces it. A single-write mode cuts every write to one beat and leaves reads at the programmed length. Full-row length combined with interleaved ordering is illegal, and so are the reserved codes. These settings run as an eight-beat burst and set a sticky error flag.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is applied, and until the first start after it, valid_o, last_o and cfg_err_o are all 0.
- R2: A start_i sampled at a clock edge makes valid_o 1 on the following cycle, with col_o equal to the sampled start_col_i. Length codes: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, 7 gives a full row.
- R3: With interleave_i at 0, beat k of an N-beat burst (N = 1, 2, 4 or 8) is (start & ~(N-1)) | ((start + k) mod N).
- R4: With interleave_i at 1, beat k is (start & ~(N-1)) | ((start mod N) XOR k).
- R5: A full-row burst (code 7, sequential) gives (start + k) mod 512 on beat k. It never raises last_o and keeps going after 512 beats.
- R6: last_o is 1 only on the final beat of a fixed-length burst, and valid_o drops on the next cycle unless a start was sampled. A 1-beat burst shows valid_o and last_o together on a single cycle.
- R7: If stop_i is sampled without start_i, the beat on col_o in that cycle is the last one, and valid_o is 0 on the following cycle. If start_i and stop_i are sampled together, the start takes effect.
- R8: A start_i sampled during an active burst drops that burst. The new sequence begins on the next cycle from its own start column, length and ordering.
- R9: With single_write_i at 1, a burst started with is_write_i at 1 is one beat long, and a read still uses the programmed length. With single_write_i at 0, writes use the programmed length.
- R10: Code 7 with interleave_i at 1, or codes 4, 5 and 6, run as an 8-beat burst in the selected ordering. A full row is treated as sequential. These settings set cfg_err_o, which stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start a new burst; also replaces an active one |
| start_col_i | input | 9 | First column of the burst |
| bl_code_i | input | 3 | Burst-length code (see R2, R10) |
| interleave_i | input | 1 | 1 selects interleaved ordering |
| is_write_i | input | 1 | 1 when the burst being started is a write |
| single_write_i | input | 1 | 1 limits writes to one beat |
| stop_i | input | 1 | Terminate the active burst |
| col_o | output | 9 | Column for the current beat |
| valid_o | output | 1 | col_o holds a burst beat |
| last_o | output | 1 | Final beat of a fixed-length burst |
| cfg_err_o | output | 1 | Sticky flag for an illegal length/ordering setting |

## Verification
The hardest case to reach is a full-row burst that runs past its own starting column and wraps through the row end. It needs more than 512 uninterrupted beats before the terminate strobe arrives. The stimulus starts such a burst near the top of the row and holds it for over 520 cycles. It also places start and terminate strobes on the exact final beat of bursts, and together in one cycle, so the priority rules meet the wrap and end logic.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  localparam logic [2:0] BL_CODE_1    = 3'd0;
  localparam logic [2:0] BL_CODE_2    = 3'd1;
  localparam logic [2:0] BL_CODE_4    = 3'd2;
  localparam logic [2:0] BL_CODE_8    = 3'd3;
  localparam logic [2:0] BL_CODE_FULL = 3'd7;

  typedef struct packed {
    logic       full;
    logic       il;
    logic       illegal;
    logic [1:0] len_log;
  } burst_cfg_t;
endpackage

// File: rtl/bcg_rst_sync.sv
module bcg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/bcg_cfg_decode.sv
module bcg_cfg_decode
  import burst_col_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic [2:0]       bl_code,
  input  logic             interleave,
  input  logic             is_write,
  input  logic             single_write,
  output logic [COL_W-1:0] mask,
  output burst_cfg_t       cfg
);
  always_comb begin
    cfg.il      = interleave;
    cfg.full    = 1'b0;
    cfg.illegal = 1'b0;
    cfg.len_log = 2'd3;
    unique case (bl_code)
      BL_CODE_1: cfg.len_log = 2'd0;
      BL_CODE_2: cfg.len_log = 2'd1;
      BL_CODE_4: cfg.len_log = 2'd2;
      BL_CODE_8: cfg.len_log = 2'd3;
      BL_CODE_FULL: begin
        if (interleave) cfg.illegal = 1'b1;
        else            cfg.full    = 1'b1;
      end
      default: cfg.illegal = 1'b1;
    endcase
    if (is_write && single_write) begin
      cfg.full    = 1'b0;
      cfg.len_log = 2'd0;
    end
  end

  always_comb begin
    if (cfg.full) begin
      mask = '1;
    end else begin
      unique case (cfg.len_log)
        2'd0:    mask = '0;
        2'd1:    mask = COL_W'(1);
        2'd2:    mask = COL_W'(3);
        default: mask = COL_W'(7);
      endcase
    end
  end
endmodule

// File: rtl/bcg_col_map.sv
module bcg_col_map #(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] beat,
  input  logic [COL_W-1:0] mask,
  input  logic             il,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] offs;

  always_comb begin
    if (il) offs = base ^ beat;
    else    offs = base + beat;
    col = (base & ~mask) | (offs & mask);
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       bl_code_i,
  input  logic             interleave_i,
  input  logic             is_write_i,
  input  logic             single_write_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o,
  output logic             cfg_err_o
);
  logic             rst_sync_n;
  logic [COL_W-1:0] dec_mask;
  burst_cfg_t       dec_cfg;

  logic [COL_W-1:0] base_q, mask_q, cnt_q, col_q;
  logic             full_q, il_q, vld_q, last_q, err_q;

  logic [COL_W-1:0] base_d, mask_d, cnt_d, col_d;
  logic             full_d, il_d, vld_d, last_d, err_d;
  logic             cfg_en, cnt_en, col_en;

  bcg_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  bcg_cfg_decode #(.COL_W(COL_W)) dec_i (
    .bl_code      (bl_code_i),
    .interleave   (interleave_i),
    .is_write     (is_write_i),
    .single_write (single_write_i),
    .mask         (dec_mask),
    .cfg          (dec_cfg)
  );

  always_comb begin
    cfg_en = start_i;
    base_d = cfg_en ? start_col_i  : base_q;
    mask_d = cfg_en ? dec_mask     : mask_q;
    full_d = cfg_en ? dec_cfg.full : full_q;
    il_d   = cfg_en ? dec_cfg.il   : il_q;
    err_d  = err_q | (cfg_en & dec_cfg.illegal);

    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    vld_d  = 1'b0;
    if (start_i) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
      vld_d  = 1'b1;
    end else if (vld_q && !stop_i && !last_q) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + COL_W'(1);
      vld_d  = 1'b1;
    end
    col_en = vld_d;
    last_d = vld_d && !full_d && (cnt_d == mask_d);
  end

  bcg_col_map #(.COL_W(COL_W)) map_i (
    .base (base_d),
    .beat (cnt_d),
    .mask (mask_d),
    .il   (il_d),
    .col  (col_d)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      base_q <= '0;
      mask_q <= '0;
      full_q <= 1'b0;
      il_q   <= 1'b0;
    end else if (cfg_en) begin
      base_q <= base_d;
      mask_q <= mask_d;
      full_q <= full_d;
      il_q   <= il_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  cnt_q <= '0;
    else if (cnt_en)  cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  col_q <= '0;
    else if (col_en)  col_q <= col_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q  <= 1'b0;
      last_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      vld_q  <= vld_d;
      last_q <= last_d;
      err_q  <= err_d;
    end
  end

  assign col_o     = col_q;
  assign valid_o   = vld_q;
  assign last_o    = last_q;
  assign cfg_err_o = err_q;
endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
  parameter int COL_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic [2:0]       bl_code_i,
  input logic             interleave_i,
  input logic             is_write_i,
  input logic             single_write_i,
  input logic             stop_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o,
  input logic             cfg_err_o
);
  assert_start_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (valid_o && col_o == $past(start_col_i)));

  assert_stop_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !start_i) |=> !valid_o);

  assert_last_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && !start_i) |=> !valid_o);

  assert_last_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o);

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err_o |=> cfg_err_o);

  assert_single_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && is_write_i && single_write_i) |=> last_o);

  assert_full_no_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && bl_code_i == 3'd7 && !interleave_i && !(is_write_i && single_write_i))
      |=> !last_o);
endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) chk_i (
  .clk            (clk),
  .rst_n          (rst_sync_n),
  .start_i        (start_i),
  .start_col_i    (start_col_i),
  .bl_code_i      (bl_code_i),
  .interleave_i   (interleave_i),
  .is_write_i     (is_write_i),
  .single_write_i (single_write_i),
  .stop_i         (stop_i),
  .col_o          (col_o),
  .valid_o        (valid_o),
  .last_o         (last_o),
  .cfg_err_o      (cfg_err_o)
);

// File: tb/burst_col_gen_tb.sv
module burst_col_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int COL_W = 9;
  localparam int ROW = 512;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [COL_W-1:0] start_col_i = '0;
  logic [2:0]       bl_code_i = '0;
  logic             interleave_i = 1'b0;
  logic             is_write_i = 1'b0;
  logic             single_write_i = 1'b0;
  logic             stop_i = 1'b0;
  logic [COL_W-1:0] col_o;
  logic             valid_o, last_o, cfg_err_o;

  int    n_checks = 0;
  int    n_errors = 0;
  bit    done = 0;
  string cur_req = "R1";

  // reference model state
  bit m_act = 0, m_fp = 0, m_il = 0, m_err = 0;
  int m_k = 0, m_len = 1, m_base = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_col_gen #(.COL_W(COL_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .bl_code_i(bl_code_i), .interleave_i(interleave_i), .is_write_i(is_write_i),
    .single_write_i(single_write_i), .stop_i(stop_i), .col_o(col_o),
    .valid_o(valid_o), .last_o(last_o), .cfg_err_o(cfg_err_o));

  function automatic int exp_col();
    int al, off;
    if (m_fp) return (m_base + m_k) % ROW;
    al  = m_base - (m_base % m_len);
    off = m_base % m_len;
    if (m_il) return al + (off ^ m_k);
    return al + ((off + m_k) % m_len);
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_update();
    if (start_i) begin
      m_act = 1; m_k = 0; m_base = int'(start_col_i);
      m_il = interleave_i; m_fp = 0;
      case (bl_code_i)
        3'd0: m_len = 1;
        3'd1: m_len = 2;
        3'd2: m_len = 4;
        3'd3: m_len = 8;
        3'd7: begin
          if (interleave_i) begin m_len = 8; m_err = 1; end
          else begin m_len = ROW; m_fp = 1; end
        end
        default: begin m_len = 8; m_err = 1; end
      endcase
      if (is_write_i && single_write_i) begin m_len = 1; m_fp = 0; end
    end else if (stop_i) begin
      m_act = 0;
    end else if (m_act) begin
      if (!m_fp && m_k == m_len - 1) m_act = 0;
      else m_k++;
    end
  endtask

  task automatic compare();
    check(cur_req, "valid_o", int'(valid_o), int'(m_act));
    check(cur_req, "last_o", int'(last_o), int'(m_act && !m_fp && m_k == m_len - 1));
    check(cur_req, "cfg_err_o", int'(cfg_err_o), int'(m_err));
    if (m_act) check(cur_req, "col_o", int'(col_o), exp_col());
  endtask

  task automatic step();
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare();
    start_i = 0;
    stop_i  = 0;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic begin_burst(int col, int code, bit il, bit wr, bit sw);
    start_i = 1; start_col_i = COL_W'(col); bl_code_i = 3'(code);
    interleave_i = il; is_write_i = wr; single_write_i = sw;
    step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    check("R1", "valid_o in reset", int'(valid_o), 0);
    check("R1", "last_o in reset", int'(last_o), 0);
    check("R1", "cfg_err_o in reset", int'(cfg_err_o), 0);
    rst_n = 1;
    run(4);

    cur_req = "R3"; begin_burst(13, 2, 0, 0, 0); run(5);   // 13 14 15 12
    cur_req = "R3"; begin_burst(5, 3, 0, 0, 0);  run(9);
    cur_req = "R2"; begin_burst(7, 1, 0, 0, 0);  run(3);
    cur_req = "R6"; begin_burst(100, 0, 0, 0, 0); run(2);  // one beat, valid+last
    cur_req = "R4"; begin_burst(29, 3, 1, 0, 0); run(9);   // 29 28 31 30 25 24 27 26
    cur_req = "R4"; begin_burst(6, 2, 1, 0, 0);  run(5);

    cur_req = "R5"; begin_burst(508, 7, 0, 0, 0); run(524);
    stop_i = 1; step(); run(2);

    cur_req = "R7"; begin_burst(40, 3, 0, 0, 0); run(2);
    stop_i = 1; step(); run(3);
    cur_req = "R7"; begin_burst(40, 3, 0, 0, 0); run(1);
    stop_i = 1; start_i = 1; start_col_i = 9'd200; bl_code_i = 3'd2; step(); run(5);

    cur_req = "R8"; begin_burst(64, 3, 0, 0, 0); run(3);
    begin_burst(18, 2, 1, 0, 0); run(1);
    begin_burst(300, 1, 0, 0, 0); run(3);
    cur_req = "R6"; begin_burst(8, 1, 0, 0, 0); run(1);
    begin_burst(50, 0, 0, 0, 0); run(2);                   // start on last beat

    cur_req = "R9"; begin_burst(77, 3, 0, 1, 1); run(3);
    begin_burst(77, 3, 0, 0, 1); run(9);
    begin_burst(77, 3, 0, 1, 0); run(9);
    begin_burst(400, 7, 0, 1, 1); run(3);

    cur_req = "R10"; begin_burst(11, 7, 1, 0, 0); run(9);
    begin_burst(3, 2, 0, 0, 0); run(6);
    begin_burst(21, 5, 0, 0, 0); run(10);
    check("R10", "cfg_err_o sticky", int'(cfg_err_o), 1);

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end
endmodule